// File: doc/BRIEF.md
# SDRAM Row/Column Access Sequencer

This block drives one bank of a single-data-rate SDRAM for read traffic. It takes one read request at a time, made of a row, a starting column and a burst-length code. It turns each request into timed commands on a shared address bus: activate, read and precharge. Each command is a level pattern on three active-low strobes. Data words coming back from the device are captured at a fixed latency after the read, one word per clock, and presented on a valid/data output pair.

The sequencer keeps the last activated row open. A request to that row goes straight to a column read. A request to any other row first closes the open row and then activates the new one. Five timing values are applied together: read latency, activate-to-read delay, precharge-to-activate delay, activate-to-precharge minimum, and the minimum spacing between commands (one or two clocks). These values come in on input pins. They are latched once, at the first clock edge after reset is released, and stay fixed until the next reset.

Top module: `sdram_seq`

## Requirements
- R1: While reset is asserted the strobes read 3'b111, `req_ready_o` is low and `rd_valid_o` is low. `req_ready_o` goes high one clock after reset release.
- R2: The strobe triple {ras_n, cas_n, we_n} only takes these values: 3'b111 for idle, 3'b011 for activate (row on the address bus), 3'b101 for read (start column on the address bus), 3'b010 for precharge.
- R3: A read to a freshly activated row issues exactly max(tRCD, command rate) clocks after the activate, if the request is already waiting.
- R4: The first data word is captured at the edge that lies CL clocks after the edge that sampled the read. The following words are captured on consecutive edges. Each captured word appears on `rd_data_o` with `rd_valid_o` high for the cycle that follows its capture edge. CL is 3 when `cfg_cl_i` is 3 and 2 otherwise.
- R5: Burst code 0 yields 2 words, code 1 yields 4 words, and codes 2 and 3 yield 8 words. Exactly that many words are captured per read.
- R6: A request whose row equals the open row is served by a read alone, with no activate or precharge.
- R7: A request to a different row first causes a precharge. The precharge is sampled at max(activate edge + tRAS, last read edge + CL + burst words). No read follows a precharge until the next activate.
- R8: After a precharge, the next activate is sampled exactly max(tRP, command rate) clocks later when a request is waiting.
- R9: Any two non-idle commands are at least the command rate apart: 2 clocks when `cfg_cr2_i` is high, 1 clock otherwise.
- R10: Timing inputs are latched at the first edge after reset release. Later changes on those pins have no effect until the next reset. `req_ready_o` stays low until they are latched.
- R11: Exactly one request is held. `req_ready_o` is low from the accepting edge until that request's read has issued.
- R12: Back-to-back reads to the open row are spaced by exactly max(previous burst words, command rate) clocks. Their data therefore arrives without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cl_i | input | 2 | Read latency, 2 or 3 |
| cfg_cr2_i | input | 1 | High selects a two-clock command spacing |
| cfg_trcd_i | input | TIM_W | Activate-to-read clocks |
| cfg_trp_i | input | TIM_W | Precharge-to-activate clocks |
| cfg_tras_i | input | TIM_W | Activate-to-precharge minimum clocks |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge when valid is high |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request starting column |
| req_bl_i | input | 2 | Burst-length code |
| sd_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write-enable strobe, active low |
| sd_dq_i | input | D_W | Data from the device |
| rd_valid_o | output | 1 | Captured word valid |
| rd_data_o | output | D_W | Captured word |

## Verification
Every configuration of latency, command rate, tRCD, tRP and tRAS in a small grid runs the same six-request pattern. The pattern has a cold activate, two open-row hits with growing bursts, a miss with the largest burst code, a hit whose columns wrap, and a final miss. The cold activate separates the activate-to-read path from the hit path. The two hits show whether read spacing follows the previous burst length or the command rate. The misses show whether the precharge slot comes from tRAS or from the end of the burst: with tRAS at 1 the burst end decides, and with tRAS at 7 tRAS dominates whenever the burst ends earlier. After each latch, the timing pins are driven to wrong values, so any late use of them shows up as a misplaced command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010
  } cmd_e;

  typedef enum logic {
    ST_CLOSED = 1'b0,
    ST_OPEN   = 1'b1
  } row_st_e;

  localparam int unsigned NT    = 6;
  localparam int unsigned T_CR  = 0; // any command to next command
  localparam int unsigned T_RCD = 1; // activate to read
  localparam int unsigned T_RAS = 2; // activate to precharge
  localparam int unsigned T_RP  = 3; // precharge to activate
  localparam int unsigned T_RR  = 4; // read to read
  localparam int unsigned T_RTP = 5; // read to precharge (burst drained)

  function automatic logic [3:0] bl_words(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         ok_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i && val_i != '0) begin
      cnt_q <= val_i - W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  // ok at the edge val_i clocks after the load edge
  assign ok_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_seq_capture.sv
module sdram_seq_capture #(
  parameter int unsigned D_W  = 16,
  parameter int unsigned CL_W = 2,
  parameter int unsigned BL_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [BL_W-1:0] bl_i,
  input  logic [CL_W-1:0] cl_i,
  input  logic [D_W-1:0]  dq_i,
  output logic            vld_o,
  output logic [D_W-1:0]  data_o
);

  localparam int unsigned SH_D = 2 ** CL_W;

  logic [BL_W-1:0] left_q;
  logic [SH_D-1:0] sh_q;
  logic [CL_W-1:0] tap_idx;
  logic            tap;

  // command reaches the device one edge after start; word 0 at that edge + CL
  assign tap_idx = cl_i - CL_W'(1);
  assign tap     = sh_q[tap_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sh_q   <= '0;
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      if (start_i) begin
        left_q <= bl_i;
      end else if (left_q != '0) begin
        left_q <= left_q - BL_W'(1);
      end
      sh_q  <= {sh_q[SH_D-2:0], left_q != '0};
      vld_o <= tap;
      if (tap) begin
        data_o <= dq_i;
      end
    end
  end

endmodule

// File: rtl/sdram_seq_cmd.sv
module sdram_seq_cmd
  import sdram_seq_pkg::*;
#(
  parameter int unsigned A_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  cmd_e           cmd_i,
  input  logic [A_W-1:0] addr_i,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [A_W-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ras_n_o, cas_n_o, we_n_o} <= 3'b111;
      addr_o                     <= '0;
    end else begin
      {ras_n_o, cas_n_o, we_n_o} <= cmd_i;
      addr_o                     <= addr_i;
    end
  end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned COL_W = 9,
  parameter int unsigned D_W   = 16,
  parameter int unsigned TIM_W = 5,
  localparam int unsigned A_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_cl_i,
  input  logic             cfg_cr2_i,
  input  logic [TIM_W-1:0] cfg_trcd_i,
  input  logic [TIM_W-1:0] cfg_trp_i,
  input  logic [TIM_W-1:0] cfg_tras_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [1:0]       req_bl_i,
  output logic [A_W-1:0]   sd_addr_o,
  output logic             sd_ras_n_o,
  output logic             sd_cas_n_o,
  output logic             sd_we_n_o,
  input  logic [D_W-1:0]   sd_dq_i,
  output logic             rd_valid_o,
  output logic [D_W-1:0]   rd_data_o
);

  localparam int unsigned CL_W = 2;
  localparam int unsigned BL_W = 4;

  // latched timing
  logic             lock_q;
  logic [CL_W-1:0]  cl_q;
  logic             cfg_cr2_q;
  logic [TIM_W-1:0] trcd_q, trp_q, tras_q;

  // held request
  logic             pend_v_q;
  logic [ROW_W-1:0] pend_row_q;
  logic [COL_W-1:0] pend_col_q;
  logic [1:0]       pend_bl_q;

  row_st_e          st_q;
  logic [ROW_W-1:0] open_row_q;

  cmd_e             cmd_n;
  logic [A_W-1:0]   addr_n;
  logic [BL_W-1:0]  pend_words;

  logic [NT-1:0]    t_load, t_ok;
  logic [TIM_W-1:0] t_val [NT];

  function automatic logic [TIM_W-1:0] at_least_one(input logic [TIM_W-1:0] v);
    return (v == '0) ? TIM_W'(1) : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      cl_q      <= '0;
      cfg_cr2_q <= 1'b0;
      trcd_q    <= '0;
      trp_q     <= '0;
      tras_q    <= '0;
    end else if (!lock_q) begin
      lock_q    <= 1'b1;
      cl_q      <= (cfg_cl_i == 2'd3) ? 2'd3 : 2'd2;
      cfg_cr2_q <= cfg_cr2_i;
      trcd_q    <= at_least_one(cfg_trcd_i);
      trp_q     <= at_least_one(cfg_trp_i);
      tras_q    <= at_least_one(cfg_tras_i);
    end
  end

  assign req_ready_o = lock_q && !pend_v_q;
  assign pend_words  = bl_words(pend_bl_q);

  // command selection
  always_comb begin
    cmd_n  = CMD_NOP;
    addr_n = '0;
    if (lock_q && pend_v_q && t_ok[T_CR]) begin
      if (st_q == ST_CLOSED) begin
        if (t_ok[T_RP]) begin
          cmd_n  = CMD_ACT;
          addr_n = A_W'(pend_row_q);
        end
      end else if (pend_row_q == open_row_q) begin
        if (t_ok[T_RCD] && t_ok[T_RR]) begin
          cmd_n  = CMD_RD;
          addr_n = A_W'(pend_col_q);
        end
      end else if (t_ok[T_RAS] && t_ok[T_RTP]) begin
        cmd_n = CMD_PRE;
      end
    end
  end

  always_comb begin
    t_load         = '0;
    t_load[T_CR]   = (cmd_n != CMD_NOP);
    t_load[T_RCD]  = (cmd_n == CMD_ACT);
    t_load[T_RAS]  = (cmd_n == CMD_ACT);
    t_load[T_RP]   = (cmd_n == CMD_PRE);
    t_load[T_RR]   = (cmd_n == CMD_RD);
    t_load[T_RTP]  = (cmd_n == CMD_RD);
    t_val[T_CR]    = cfg_cr2_q ? TIM_W'(2) : TIM_W'(1);
    t_val[T_RCD]   = trcd_q;
    t_val[T_RAS]   = tras_q;
    t_val[T_RP]    = trp_q;
    t_val[T_RR]    = TIM_W'(pend_words);
    t_val[T_RTP]   = TIM_W'(cl_q) + TIM_W'(pend_words);
  end

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    sdram_seq_timer #(.W(TIM_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (t_load[g]),
      .val_i  (t_val[g]),
      .ok_o   (t_ok[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q   <= 1'b0;
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_bl_q  <= '0;
      st_q       <= ST_CLOSED;
      open_row_q <= '0;
    end else begin
      if (cmd_n == CMD_RD) begin
        pend_v_q <= 1'b0;
      end else if (req_valid_i && req_ready_o) begin
        pend_v_q   <= 1'b1;
        pend_row_q <= req_row_i;
        pend_col_q <= req_col_i;
        pend_bl_q  <= req_bl_i;
      end
      if (cmd_n == CMD_ACT) begin
        st_q       <= ST_OPEN;
        open_row_q <= pend_row_q;
      end else if (cmd_n == CMD_PRE) begin
        st_q <= ST_CLOSED;
      end
    end
  end

  sdram_seq_cmd #(.A_W(A_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_n),
    .addr_i  (addr_n),
    .ras_n_o (sd_ras_n_o),
    .cas_n_o (sd_cas_n_o),
    .we_n_o  (sd_we_n_o),
    .addr_o  (sd_addr_o)
  );

  sdram_seq_capture #(.D_W(D_W), .CL_W(CL_W), .BL_W(BL_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_n == CMD_RD),
    .bl_i    (pend_words),
    .cl_i    (cl_q),
    .dq_i    (sd_dq_i),
    .vld_o   (rd_valid_o),
    .data_o  (rd_data_o)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int unsigned TIM_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n_i,
  input logic             cas_n_i,
  input logic             we_n_i,
  input logic             req_valid_i,
  input logic             req_ready_i,
  input logic             lock_i,
  input logic             cr2_i,
  input logic [TIM_W-1:0] trcd_i
);

  logic [2:0] c;
  assign c = {ras_n_i, cas_n_i, we_n_i};

  p_cmd_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c inside {3'b111, 3'b011, 3'b101, 3'b010});

  p_cr_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr2_i && c != 3'b111) |=> (c == 3'b111));

  p_rcd_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c == 3'b011 && trcd_i >= TIM_W'(2)) |=> (c != 3'b101));

  p_pre_no_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c == 3'b010) |=> (c != 3'b101));

  p_one_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_i) |=> !req_ready_i);

  p_ready_after_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> !req_ready_i);

endmodule

bind sdram_seq sdram_seq_chk #(.TIM_W(TIM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ras_n_i     (sd_ras_n_o),
  .cas_n_i     (sd_cas_n_o),
  .we_n_i      (sd_we_n_o),
  .req_valid_i (req_valid_i),
  .req_ready_i (req_ready_o),
  .lock_i      (lock_q),
  .cr2_i       (cfg_cr2_q),
  .trcd_i      (trcd_q)
);

// File: tb/sim_sdram_seq.sv
module sim_sdram_seq;

  localparam int CLK_P   = 10;
  localparam int ROW_W   = 12;
  localparam int COL_W   = 9;
  localparam int D_W     = 16;
  localparam int TIM_W   = 5;
  localparam int NREQ    = 6;
  localparam int CYC_MAX = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_cl = 2'd2;
  logic             cfg_cr2 = 1'b0;
  logic [TIM_W-1:0] cfg_trcd = 5'd1, cfg_trp = 5'd1, cfg_tras = 5'd1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [1:0]       req_bl = '0;
  logic [ROW_W-1:0] sd_addr;
  logic             ras_n, cas_n, we_n;
  logic [D_W-1:0]   sd_dq = '0;
  logic             rd_valid;
  logic [D_W-1:0]   rd_data;

  sdram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .D_W(D_W), .TIM_W(TIM_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_cl_i(cfg_cl), .cfg_cr2_i(cfg_cr2), .cfg_trcd_i(cfg_trcd),
    .cfg_trp_i(cfg_trp), .cfg_tras_i(cfg_tras),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(req_row), .req_col_i(req_col), .req_bl_i(req_bl),
    .sd_addr_o(sd_addr), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_dq_i(sd_dq), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int ecnt = 0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  // request pattern: cold open, hit, hit, miss, hit with column wrap, miss
  int rq_row [NREQ] = '{5, 5, 5, 9, 9, 2};
  int rq_col [NREQ] = '{10, 20, 33, 7, 510, 1};
  int rq_bl  [NREQ] = '{0, 1, 2, 3, 1, 1};

  // model of the device and its latched timing
  int  m_cl, m_cr, m_rcd, m_rp, m_ras;
  bit  mon_en = 1'b0;
  bit  m_open, had_cmd, had_rd, have_pre;
  int  m_row, act_e, pre_e, rd_e, last_e, last_bl;
  int  n_act, n_pre, n_rd;
  int  exp_e [64];
  logic [D_W-1:0] exp_d [64];
  int  eh, et;
  logic [D_W-1:0] ring [32];

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int words_of(int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction

  function automatic logic [D_W-1:0] word_of(int row, int col);
    logic [7:0] r8, c8;
    r8 = 8'(row) ^ 8'h5a;
    c8 = 8'(col % 512);
    return {r8, c8};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ecnt <= ecnt + 1;
    cyc  <= cyc + 1;
    if (cyc > CYC_MAX) begin
      errors++;
      $display("FAIL watchdog all-R cycles actual=%0d expected=%0d", cyc, CYC_MAX);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bus monitor and device model; the bus seen now is sampled at edge ecnt+1
  always @(negedge clk) begin
    int e;
    int bl;
    logic [2:0] c;
    if (mon_en) begin
      e = ecnt + 1;
      c = {ras_n, cas_n, we_n};
      if (c != 3'b111 && had_cmd)
        chk(e - last_e >= m_cr, "R9 command spacing", e - last_e, m_cr);
      if (c != 3'b111) begin
        had_cmd = 1'b1;
        last_e  = e;
      end
      case (c)
        3'b011: begin
          chk(!m_open, "R7 activate while row open", int'(m_open), 0);
          chk(n_rd < NREQ && int'(sd_addr) == rq_row[n_rd % NREQ], "R2 activate row",
              int'(sd_addr), rq_row[n_rd % NREQ]);
          if (have_pre)
            chk(e - pre_e == max2(m_rp, m_cr), "R8 activate after precharge",
                e - pre_e, max2(m_rp, m_cr));
          m_open = 1'b1; m_row = int'(sd_addr); act_e = e; had_rd = 1'b0; n_act++;
        end
        3'b101: begin
          chk(m_open, "R6 read needs open row", int'(m_open), 1);
          if (n_rd < NREQ) begin
            chk(int'(sd_addr) == rq_col[n_rd], "R2 read column", int'(sd_addr), rq_col[n_rd]);
            if (!had_rd)
              chk(e - act_e == max2(m_rcd, m_cr), "R3 read after activate",
                  e - act_e, max2(m_rcd, m_cr));
            else
              chk(e - rd_e == max2(last_bl, m_cr), "R12 read to read spacing",
                  e - rd_e, max2(last_bl, m_cr));
            bl = words_of(rq_bl[n_rd]);
            for (int i = 0; i < bl; i++) begin
              ring[(e + m_cl + i) % 32] = word_of(m_row, rq_col[n_rd] + i);
              exp_e[et % 64] = e + m_cl + i;
              exp_d[et % 64] = word_of(rq_row[n_rd], rq_col[n_rd] + i);
              et++;
            end
            rd_e = e; last_bl = bl; had_rd = 1'b1;
          end else begin
            chk(1'b0, "R11 read without request", n_rd, NREQ - 1);
          end
          n_rd++;
        end
        3'b010: begin
          chk(m_open, "R7 precharge with row open", int'(m_open), 1);
          chk(e == max2(act_e + m_ras, rd_e + m_cl + last_bl), "R7 precharge slot",
              e - act_e, max2(m_ras, rd_e + m_cl + last_bl - act_e));
          m_open = 1'b0; pre_e = e; have_pre = 1'b1; n_pre++;
        end
        3'b111: ;
        default: chk(1'b0, "R2 strobe code", int'(c), 7);
      endcase
      // rd_valid now reports a word captured at edge ecnt
      if (rd_valid) begin
        if (eh < et) begin
          chk(ecnt == exp_e[eh % 64], "R4 word capture edge", ecnt, exp_e[eh % 64]);
          chk(rd_data == exp_d[eh % 64], "R4 word data", int'(rd_data), int'(exp_d[eh % 64]));
          eh++;
        end else begin
          chk(1'b0, "R5 extra word", int'(rd_data), -1);
        end
      end else if (eh < et && exp_e[eh % 64] <= ecnt) begin
        chk(1'b0, "R5 missing word", ecnt, exp_e[eh % 64]);
        eh++;
      end
      sd_dq <= ring[(ecnt + 1) % 32];
    end
  end

  task automatic send(input int idx);
    req_row   = ROW_W'(rq_row[idx]);
    req_col   = COL_W'(rq_col[idx]);
    req_bl    = 2'(rq_bl[idx]);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low after accept", int'(req_ready), 0);
  endtask

  task automatic run_cfg(input int cl, input int cr, input int rcd, input int rp, input int ras);
    mon_en  = 1'b0;
    @(negedge clk);
    rst_n   = 1'b0;
    cfg_cl  = 2'(cl); cfg_cr2 = (cr == 2);
    cfg_trcd = TIM_W'(rcd); cfg_trp = TIM_W'(rp); cfg_tras = TIM_W'(ras);
    m_cl = cl; m_cr = cr; m_rcd = rcd; m_rp = rp; m_ras = ras;
    m_open = 0; had_cmd = 0; had_rd = 0; have_pre = 0;
    act_e = 0; pre_e = 0; rd_e = 0; last_e = 0; last_bl = 0;
    n_act = 0; n_pre = 0; n_rd = 0; eh = 0; et = 0;
    for (int i = 0; i < 32; i++) ring[i] = '0;
    @(negedge clk);
    // R1 reset state
    chk({ras_n, cas_n, we_n} == 3'b111 && !req_ready && !rd_valid, "R1 reset outputs",
        int'({ras_n, cas_n, we_n, req_ready, rd_valid}), 5'b11100);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after latch", int'(req_ready), 1);
    // R10: scramble timing pins after the latch edge
    cfg_cl = (cl == 3) ? 2'd2 : 2'd3; cfg_cr2 = (cr != 2);
    cfg_trcd = TIM_W'(rcd + 9); cfg_trp = TIM_W'(rp + 11); cfg_tras = TIM_W'(ras + 13);
    for (int r = 0; r < NREQ; r++) send(r);
    for (int w = 0; w < 400 && !(n_rd == NREQ && eh == et); w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_rd == NREQ && eh == et && et > 0, "R5 all words delivered R10", eh, et);
    chk(n_act == 3, "R6 activate count", n_act, 3);
    chk(n_pre == 2, "R7 precharge count", n_pre, 2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int cl = 2; cl <= 3; cl++)
      for (int cr = 1; cr <= 2; cr++)
        for (int rcd = 1; rcd <= 3; rcd++)
          for (int rp = 1; rp <= 3; rp += 2)
            for (int ras = 1; ras <= 7; ras += 6)
              run_cfg(cl, cr, rcd, rp, ras);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule